// File: doc/BRIEF.md
# Three-Wire Settings Receiver

This block takes a write-only three-wire control link (control clock, mode line, data line) and turns it into the setting registers of an audio converter: clock ratio, serial input format, volume, de-emphasis and mute. All three wires are asynchronous to the fast system clock. They pass through a synchroniser, and each bit is taken on a rising edge of the control clock as seen in the system domain. Bits arrive least significant first, in groups of eight. A byte counts only once all eight bits are in. Any change on the mode line throws away a byte that is still incomplete.

A low mode line marks an address byte. The upper six bits of that byte must equal the device address for the block to respond. The lower two bits choose which group of settings the following bytes reach. A high mode line marks a data byte. The top two bits of a data byte choose a register inside the selected group, and the remaining bits carry the value.

A small state machine holds the selection. In ST_IDLE the block is not selected, or the chosen transfer type is unused. In ST_DATA it is selected for volume, de-emphasis and mute. In ST_STATUS it is selected for clock ratio and input format. The state changes only on address bytes. A matching address with type 00 goes to ST_DATA, a matching address with type 10 goes to ST_STATUS, and any other address byte goes to ST_IDLE. Data bytes leave the state unchanged.

Top module: `ctrl_port_rx`

## Requirements
- R1: After reset the settings are volume 000000, de-emphasis 00, mute 0, clock ratio 10 (256fs) and input format 000.
- R2: Eight rising edges of the control clock with the mode line steady form one byte, with the first bit received placed at bit 0. Settings change only after the eighth bit. A change on the mode line discards any partial byte, so the next byte starts again at bit 0.
- R3: An address byte (mode line low) whose bits 7..2 are not 000101 deselects the block, and later data bytes change no setting. No address byte changes a setting itself.
- R4: In a matching address byte, bits 1..0 = 00 select the data group and 10 select the status group. The values 01 and 11 leave the block with no group selected, so later data bytes change no setting.
- R5: The selected group stays in force for any number of data bytes until the next address byte arrives.
- R6: In the status group, a byte with bits 7..6 = 00 loads the clock ratio from bits 5..4 and the input format from bits 3..1. Every other status byte, including 10000000, has no effect. Status bytes never alter volume, de-emphasis or mute.
- R7: In the data group, a byte with bits 7..6 = 00 loads the 6-bit volume from bits 5..0.
- R8: In the data group, a byte with bits 7..6 = 10 loads de-emphasis from bits 4..3 and mute from bit 2, and leaves volume unchanged.
- R9: In the data group, a byte with bits 7..6 = 01, or with bits 7..6 = 11 but not equal to 11000001, has no effect.
- R10: In the data group, the byte 11000001 returns all five settings to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_clk | input | 1 | Control-link clock, asynchronous |
| cp_mode | input | 1 | Control-link mode: 0 address, 1 data |
| cp_data | input | 1 | Control-link serial data, least significant bit first |
| clk_ratio | output | 2 | Clock ratio code: 00 512fs, 01 384fs, 10 256fs, 11 unused |
| in_fmt | output | 3 | Serial input format code |
| volume | output | 6 | Volume attenuation code |
| deemph | output | 2 | De-emphasis selection |
| mute | output | 1 | Soft mute enable |

## Verification
Directed sequences cover the cases that decide whether a byte reaches a register. These are a correct address with each transfer type, a wrong address, the reserved and restore patterns in both groups, and a partial byte cut off by a mode change. A failure points at the address decoder, the group selection or the bit counter. The sequences that alternate group selection separate the two register groups, and volumes with a single bit set would expose a reversed bit order. A long random mix follows. It uses mostly matching addresses with random types, the occasional foreign address, and data bytes weighted over the four prefixes. A bench model predicts every field after every byte, which checks that the selection persists and that no field written earlier is ever disturbed.

// File: rtl/ctrl_port_pkg.sv
`timescale 1ns/1ps
package ctrl_port_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int TYPE_W  = BYTE_W - ADDR_W;
    localparam int VOL_W   = 6;
    localparam int RATIO_W = 2;
    localparam int FMT_W   = 3;
    localparam int DEEM_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_STATUS = 2'd2
    } sel_state_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [FMT_W-1:0]   fmt;
        logic [VOL_W-1:0]   vol;
        logic [DEEM_W-1:0]  deemph;
        logic               mute;
    } settings_t;

    localparam settings_t SET_DEFAULT = '{
        ratio:  2'b10,
        fmt:    3'b000,
        vol:    6'b000000,
        deemph: 2'b00,
        mute:   1'b0
    };

    localparam logic [TYPE_W-1:0] TYPE_DATA   = 2'b00;
    localparam logic [TYPE_W-1:0] TYPE_STATUS = 2'b10;
    localparam logic [BYTE_W-1:0] BYTE_RESTORE = 8'b1100_0001;
endpackage

// File: rtl/ctrl_sync.sv
`timescale 1ns/1ps
module ctrl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe[s] <= '0;
                else if (s == 0)
                    pipe[s] <= async_in;
                else
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/ctrl_byte_shift.sv
`timescale 1ns/1ps
module ctrl_byte_shift
    import ctrl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_mode,
    input  logic              s_data,
    output logic              byte_vld,
    output logic              byte_mode,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W-1);

    logic              prev_clk;
    logic              prev_mode;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shifted;

    // first bit ends up at bit 0 after eight shifts
    assign shifted = {s_data, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk  <= 1'b0;
            prev_mode <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_mode <= 1'b0;
            byte_q    <= '0;
        end else begin
            prev_clk  <= s_clk;
            prev_mode <= s_mode;
            byte_vld  <= 1'b0;
            if (s_mode != prev_mode) begin
                bit_cnt <= '0;          // partial byte dropped
            end else if (s_clk && !prev_clk) begin
                shreg <= shifted;
                if (bit_cnt == CNT_LAST) begin
                    bit_cnt   <= '0;
                    byte_q    <= shifted;
                    byte_mode <= s_mode;
                    byte_vld  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctrl_decode.sv
`timescale 1ns/1ps
module ctrl_decode
    import ctrl_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] byte_q,
    output sel_state_t        state,
    output settings_t         cfg
);
    sel_state_t        state_nxt;
    logic [1:0]        prefix;
    logic              addr_hit;
    logic [TYPE_W-1:0] xfer_type;

    assign prefix    = byte_q[BYTE_W-1 -: 2];
    assign addr_hit  = (byte_q[BYTE_W-1 -: ADDR_W] == DEV_ADDR);
    assign xfer_type = byte_q[TYPE_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: only address bytes move the selection
    always_comb begin
        state_nxt = state;
        if (byte_vld && !byte_mode) begin
            if (!addr_hit)                     state_nxt = ST_IDLE;
            else if (xfer_type == TYPE_DATA)   state_nxt = ST_DATA;
            else if (xfer_type == TYPE_STATUS) state_nxt = ST_STATUS;
            else                               state_nxt = ST_IDLE;
        end
    end

    // setting registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= SET_DEFAULT;
        end else if (byte_vld && byte_mode) begin
            unique case (state)
                ST_DATA: begin
                    if (prefix == 2'b00) begin
                        cfg.vol <= byte_q[VOL_W-1:0];
                    end else if (prefix == 2'b10) begin
                        cfg.deemph <= byte_q[4:3];
                        cfg.mute   <= byte_q[2];
                    end else if (byte_q == BYTE_RESTORE) begin
                        cfg <= SET_DEFAULT;
                    end
                end
                ST_STATUS: begin
                    if (prefix == 2'b00) begin
                        cfg.ratio <= byte_q[5:4];
                        cfg.fmt   <= byte_q[3:1];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctrl_port_rx.sv
`timescale 1ns/1ps
module ctrl_port_rx
    import ctrl_port_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cp_clk,
    input  logic               cp_mode,
    input  logic               cp_data,
    output logic [RATIO_W-1:0] clk_ratio,
    output logic [FMT_W-1:0]   in_fmt,
    output logic [VOL_W-1:0]   volume,
    output logic [DEEM_W-1:0]  deemph,
    output logic               mute
);
    logic [2:0]        synced;
    logic              byte_vld;
    logic              byte_mode;
    logic [BYTE_W-1:0] byte_q;
    sel_state_t        dec_state;
    settings_t         cfg;

    ctrl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cp_clk, cp_mode, cp_data}),
        .sync_out (synced)
    );

    ctrl_byte_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_clk     (synced[2]),
        .s_mode    (synced[1]),
        .s_data    (synced[0]),
        .byte_vld  (byte_vld),
        .byte_mode (byte_mode),
        .byte_q    (byte_q)
    );

    ctrl_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_mode (byte_mode),
        .byte_q    (byte_q),
        .state     (dec_state),
        .cfg       (cfg)
    );

    assign clk_ratio = cfg.ratio;
    assign in_fmt    = cfg.fmt;
    assign volume    = cfg.vol;
    assign deemph    = cfg.deemph;
    assign mute      = cfg.mute;
endmodule

// File: rtl/ctrl_port_chk.sv
`timescale 1ns/1ps
module ctrl_port_chk
    import ctrl_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic              byte_mode,
    input logic [BYTE_W-1:0] byte_q,
    input logic [1:0]        state,
    input logic [1:0]        clk_ratio,
    input logic [2:0]        in_fmt,
    input logic [5:0]        volume,
    input logic [1:0]        deemph,
    input logic              mute
);
    logic [13:0] all_set;
    assign all_set = {clk_ratio, in_fmt, volume, deemph, mute};

    AST_HOLD_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(all_set)); // R2

    AST_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_mode) |=> $stable(all_set)); // R3

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_mode && state == ST_IDLE) |=> $stable(all_set)); // R4

    AST_STATUS_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_mode && state == ST_STATUS)
            |=> ($stable(volume) && $stable(deemph) && $stable(mute))); // R6

    AST_DATA_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_mode && state == ST_DATA && byte_q != BYTE_RESTORE)
            |=> ($stable(clk_ratio) && $stable(in_fmt))); // R7

    AST_FLAG_KEEPS_VOL: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_mode && state == ST_DATA && byte_q[7:6] == 2'b10)
            |=> $stable(volume)); // R8
endmodule

bind ctrl_port_rx ctrl_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_mode (byte_mode),
    .byte_q    (byte_q),
    .state     (dec_state),
    .clk_ratio (clk_ratio),
    .in_fmt    (in_fmt),
    .volume    (volume),
    .deemph    (deemph),
    .mute      (mute)
);

// File: tb/test_ctrl_port_rx.sv
`timescale 1ns/1ps
module test_ctrl_port_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cp_clk = 1'b0, cp_mode = 1'b0, cp_data = 1'b0;
    logic [1:0] clk_ratio;
    logic [2:0] in_fmt;
    logic [5:0] volume;
    logic [1:0] deemph;
    logic       mute;

    always #2.5 clk = ~clk;

    ctrl_port_rx i_ctrl_port_rx (
        .clk(clk), .rst_n(rst_n),
        .cp_clk(cp_clk), .cp_mode(cp_mode), .cp_data(cp_data),
        .clk_ratio(clk_ratio), .in_fmt(in_fmt), .volume(volume),
        .deemph(deemph), .mute(mute)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model
    int         m_sel = 0; // 0 none, 1 data, 2 status
    logic [1:0] e_ratio = 2'b10;
    logic [2:0] e_fmt   = 3'b000;
    logic [5:0] e_vol   = 6'd0;
    logic [1:0] e_de    = 2'd0;
    logic       e_mute  = 1'b0;
    string      last_tag = "R1";

    task automatic model_defaults();
        e_ratio = 2'b10; e_fmt = 3'b000; e_vol = 6'd0; e_de = 2'd0; e_mute = 1'b0;
    endtask

    task automatic model_byte(input bit md, input logic [7:0] b);
        if (!md) begin
            if (b[7:2] != 6'b000101) begin m_sel = 0; last_tag = "R3"; end
            else begin
                last_tag = "R4";
                if (b[1:0] == 2'b00) m_sel = 1;
                else if (b[1:0] == 2'b10) m_sel = 2;
                else m_sel = 0;
            end
        end else if (m_sel == 1) begin
            if (b[7:6] == 2'b00) begin e_vol = b[5:0]; last_tag = "R7"; end
            else if (b[7:6] == 2'b10) begin e_de = b[4:3]; e_mute = b[2]; last_tag = "R8"; end
            else if (b == 8'hC1) begin model_defaults(); last_tag = "R10"; end
            else last_tag = "R9";
        end else if (m_sel == 2) begin
            last_tag = "R6";
            if (b[7:6] == 2'b00) begin e_ratio = b[5:4]; e_fmt = b[3:1]; end
        end else begin
            last_tag = "R5";
        end
    endtask

    task automatic check_all(input string tag);
        n_checks++;
        if ({clk_ratio, in_fmt, volume, deemph, mute} !== {e_ratio, e_fmt, e_vol, e_de, e_mute}) begin
            n_fail++;
            $display("FAIL %s: got ratio=%b fmt=%b vol=%h de=%b mute=%b, expected ratio=%b fmt=%b vol=%h de=%b mute=%b",
                     tag, clk_ratio, in_fmt, volume, deemph, mute,
                     e_ratio, e_fmt, e_vol, e_de, e_mute);
        end
    endtask

    task automatic send_bits(input bit md, input logic [7:0] b, input int n);
        @(negedge clk);
        cp_mode = md;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            cp_data = b[i];
            repeat (6) @(negedge clk);
            cp_clk = 1'b1;
            repeat (6) @(negedge clk);
            cp_clk = 1'b0;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic send_byte(input bit md, input logic [7:0] b, input string tag);
        send_bits(md, b, 8);
        model_byte(md, b);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R2: watchdog expired, got hang, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R1 reset values");

        // R6 status writes, reserved pattern ignored
        send_byte(1'b0, {6'b000101, 2'b10}, "R4 select status");
        send_byte(1'b1, 8'b00_01_011_0, "R6 status write");
        send_byte(1'b1, 8'b1000_0000, "R6 reserved status");
        send_byte(1'b1, 8'b00_00_100_0, "R5 R6 second status byte");
        // R7 R8 data group
        send_byte(1'b0, {6'b000101, 2'b00}, "R4 select data");
        send_byte(1'b1, 8'b00_101010, "R7 volume");
        send_byte(1'b1, 8'b10_0_11_1_00, "R8 deemph and mute");
        send_byte(1'b1, 8'b00_000001, "R7 R2 volume lsb first");
        send_byte(1'b1, 8'b01_111111, "R9 reserved 01");
        send_byte(1'b1, 8'b1100_0000, "R9 reserved 11");
        // R3 foreign address
        send_byte(1'b0, {6'b000111, 2'b00}, "R3 foreign address");
        send_byte(1'b1, 8'b00_000101, "R3 data while deselected");
        // R4 unused type
        send_byte(1'b0, {6'b000101, 2'b01}, "R4 unused type 01");
        send_byte(1'b1, 8'b00_110011, "R4 data after type 01");
        send_byte(1'b0, {6'b000101, 2'b11}, "R4 unused type 11");
        send_byte(1'b1, 8'b00_110011, "R4 data after type 11");
        // R2 partial byte discarded by mode change
        send_byte(1'b0, {6'b000101, 2'b00}, "R2 select data");
        send_bits(1'b1, 8'b10_0_01_0_00, 3);
        check_all("R2 partial byte no effect");
        send_byte(1'b0, {6'b000101, 2'b00}, "R2 address after partial");
        send_byte(1'b1, 8'b00_010001, "R2 byte after partial");
        // R10 restore
        send_byte(1'b1, 8'hC1, "R10 restore defaults");

        for (int k = 0; k < 220; k++) begin
            logic [7:0] b;
            int op = int'($urandom % 5);
            if (op == 0) begin
                b[1:0] = 2'($urandom);
                b[7:2] = ($urandom % 6 != 0) ? 6'b000101 : 6'($urandom);
                send_byte(1'b0, b, "R3 R4 random address");
            end else begin
                int p = int'($urandom % 8);
                b = 8'($urandom);
                if (p < 3) b[7:6] = 2'b00;
                else if (p < 5) b[7:6] = 2'b10;
                else if (p == 5) b[7:6] = 2'b01;
                else if (p == 6) b = 8'hC1;
                else b[7:6] = 2'b11;
                send_byte(1'b1, b, {"R5 random ", last_tag});
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule